// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the data path of an 8-bit accumulator machine. It takes an operation code, the accumulator byte, a second operand byte and the current status byte. From these it produces, in the same cycle, the result byte and the status byte that follow from the operation. A write strobe copies both values into an output register pair, so that a surrounding sequencer can use either the combinational view or the registered view.

The status byte holds five flags: sign, zero, half carry, parity and carry. Each operation class has its own rule for which flags it changes. Arithmetic sets all five. The logic operations force carry and half carry to fixed values. Increment and decrement keep the carry. The rotates touch only the carry. The complement operation changes no flag. The decimal adjust uses half carry and carry to correct each nibble of a binary sum into two BCD digits.

Top module: `acc_alu`

## Requirements
- R1: The status byte layout is S at bit 7, Z at bit 6, half carry AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 of the next status byte are always 0. When an operation updates S, Z and P, S is bit 7 of its value, Z is 1 when the value is zero, and P is 1 when the value has an even number of ones.
- R2: Add (code 0) gives acc+opd, and add with carry (code 1) gives acc+opd+CY. CY is the carry out of bit 7 and AC is the carry out of bit 3. S, Z and P are updated.
- R3: Subtract (code 2) and subtract with borrow (code 3) compute acc + ~opd + cin, with cin=1 for code 2 and cin=~CY for code 3. The new CY is the inverted carry out, so it means borrow. AC is the carry out of bit 3 of that internal sum. S, Z and P are updated.
- R4: AND (code 4) gives CY=0 and AC=1. OR (code 5) and XOR (code 6) give CY=0 and AC=0. All three update S, Z and P from the result.
- R5: Compare (code 7) sets the flags exactly as subtract does, but the result is the unchanged accumulator. acc<opd gives CY=1 and Z=0, acc=opd gives CY=0 and Z=1, and acc>opd gives CY=0 and Z=0.
- R6: Increment (code 8) and decrement (code 9) act on the operand byte: opd+1, and opd+FFh with no carry in. AC is the carry out of bit 3 of that sum. S, Z and P are updated, and CY keeps its input value.
- R7: Complement (code 10) returns ~acc and leaves every flag at its input value.
- R8: Rotate left (code 11) puts bit 7 into CY and into bit 0. Rotate right (code 12) puts bit 0 into CY and into bit 7. Rotate left through carry (code 13) puts bit 7 into CY and the old CY into bit 0. Rotate right through carry (code 14) puts bit 0 into CY and the old CY into bit 7. No other flag changes.
- R9: Set carry (code 15) forces CY to 1, and complement carry (code 16) inverts CY. The result is the accumulator and no other flag changes.
- R10: Decimal adjust (code 17) adds 06h when the low nibble is above 9 or AC is set. AC becomes the carry out of bit 3 of that step. The block then adds 60h when the high nibble of the intermediate value is above 9, when CY is set, or when the first step carried out of bit 7. CY becomes 1 exactly when this second correction happens. S, Z and P are updated. For example, BAh with clear flags gives 20h with CY=1.
- R11: The result and status registers load the combinational result and next status on a clock edge where the write enable is high, and hold otherwise. An active-low reset clears both registers.
- R12: Codes 18 to 31 are reserved. They return the accumulator as the result and the input flags as the status, with bits 5, 3 and 1 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator byte |
| opd_i | input | 8 | Second operand byte |
| flg_i | input | 8 | Current status byte |
| wr_en_i | input | 1 | Loads the output registers |
| res_o | output | 8 | Combinational result |
| flg_o | output | 8 | Combinational next status |
| res_q | output | 8 | Registered result |
| flg_q | output | 8 | Registered status |

## Verification
The combinational result and next status are due in the same cycle as the operands. The bench therefore compares them against its behavioural model at the falling edge that follows each change of input. The registered pair is due one rising edge after a strobed cycle, so the model keeps its own copy of those registers. It updates that copy with the values of the cycle just sampled, and only when the strobe was high, then compares at the next falling edge. Inputs change only on falling edges, so every comparison is made half a period away from the edge that loads the registers.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBB  = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_CMP  = 5'd7,
      OP_INC  = 5'd8,
      OP_DEC  = 5'd9,
      OP_CPL  = 5'd10,
      OP_RL   = 5'd11,
      OP_RR   = 5'd12,
      OP_RLT  = 5'd13,
      OP_RRT  = 5'd14,
      OP_SETC = 5'd15,
      OP_CMCY = 5'd16,
      OP_DADJ = 5'd17
   } alu_op_e;

   localparam int OP_W  = 5;
   localparam int FB_CY = 0;
   localparam int FB_P  = 2;
   localparam int FB_AC = 4;
   localparam int FB_Z  = 6;
   localparam int FB_S  = 7;
   localparam int FLAG_W = 8;
   localparam logic [FLAG_W-1:0] FLAG_USED = 8'hD5;

endpackage

// File: rtl/acc_nib_adder.sv
module acc_nib_adder #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              ci_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              nib_c_o,
   output logic              co_o
);
   localparam int NIB_W   = 4;
   localparam int NIB_CNT = DATA_W / NIB_W;

   logic [NIB_CNT:0] carry;

   initial begin
      if ((DATA_W % NIB_W) != 0 || NIB_CNT < 2)
         $error("acc_nib_adder: DATA_W must be a multiple of 4 and at least 8");
   end

   assign carry[0] = ci_i;

   for (genvar n = 0; n < NIB_CNT; n++) begin : g_slice
      logic [NIB_W:0] part;
      assign part = {1'b0, x_i[n*NIB_W +: NIB_W]}
                  + {1'b0, y_i[n*NIB_W +: NIB_W]}
                  + {{NIB_W{1'b0}}, carry[n]};
      assign sum_o[n*NIB_W +: NIB_W] = part[NIB_W-1:0];
      assign carry[n+1] = part[NIB_W];
   end

   assign nib_c_o = carry[1];
   assign co_o    = carry[NIB_CNT];

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o,
   output logic              ac_o
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      res_o = a_i;
      cy_o  = cy_i;
      ac_o  = 1'b0;
      case (op_i)
         OP_AND: begin
            res_o = a_i & b_i;
            cy_o  = 1'b0;
            ac_o  = 1'b1;
         end
         OP_OR: begin
            res_o = a_i | b_i;
            cy_o  = 1'b0;
         end
         OP_XOR: begin
            res_o = a_i ^ b_i;
            cy_o  = 1'b0;
         end
         OP_CPL: res_o = ~a_i;
         OP_RL: begin
            res_o = {a_i[MSB-1:0], a_i[MSB]};
            cy_o  = a_i[MSB];
         end
         OP_RR: begin
            res_o = {a_i[0], a_i[MSB:1]};
            cy_o  = a_i[0];
         end
         OP_RLT: begin
            res_o = {a_i[MSB-1:0], cy_i};
            cy_o  = a_i[MSB];
         end
         OP_RRT: begin
            res_o = {cy_i, a_i[MSB:1]};
            cy_o  = a_i[0];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_dec_adjust.sv
module acc_dec_adjust #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              ac_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] res_o,
   output logic              ac_o,
   output logic              cy_o
);
   localparam int NIB_W = 4;
   localparam logic [NIB_W-1:0] DIG_MAX = 4'd9;
   localparam logic [NIB_W-1:0] FIX     = 4'd6;

   logic              lo_fix;
   logic              hi_fix;
   logic [NIB_W:0]    lo_sum;
   logic [DATA_W:0]   stage1;

   initial begin
      if (DATA_W != 2 * NIB_W)
         $error("acc_dec_adjust: only two BCD digits are supported");
   end

   assign lo_fix = (a_i[NIB_W-1:0] > DIG_MAX) | ac_i;
   assign lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, FIX};
   assign ac_o   = lo_fix & lo_sum[NIB_W];

   assign stage1 = {1'b0, a_i} + (lo_fix ? {{(DATA_W-NIB_W+1){1'b0}}, FIX} : '0);

   assign hi_fix = (stage1[DATA_W-1:NIB_W] > DIG_MAX) | cy_i | stage1[DATA_W];
   assign cy_o   = hi_fix;
   assign res_o  = stage1[DATA_W-1:0] + (hi_fix ? {FIX, {NIB_W{1'b0}}} : '0);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opd_i,
   input  logic [7:0]        flg_i,
   input  logic              wr_en_i,
   output logic [DATA_W-1:0] res_o,
   output logic [7:0]        flg_o,
   output logic [DATA_W-1:0] res_q,
   output logic [7:0]        flg_q
);
   localparam int MSB = DATA_W - 1;

   initial begin
      if (DATA_W != 8) $error("acc_alu: DATA_W must be 8");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic cy_in, ac_in;
   assign cy_in = flg_i[FB_CY];
   assign ac_in = flg_i[FB_AC];

   logic unused_flag_bits;
   assign unused_flag_bits = ^(flg_i & ~FLAG_USED);

   // adder operand steering
   logic [DATA_W-1:0] add_x, add_y, add_sum;
   logic              add_ci, add_nib, add_co, sub_mode;

   always_comb begin
      add_x    = acc_i;
      add_y    = opd_i;
      add_ci   = 1'b0;
      sub_mode = 1'b0;
      case (op)
         OP_ADC: add_ci = cy_in;
         OP_SUB, OP_CMP: begin
            add_y    = ~opd_i;
            add_ci   = 1'b1;
            sub_mode = 1'b1;
         end
         OP_SBB: begin
            add_y    = ~opd_i;
            add_ci   = ~cy_in;
            sub_mode = 1'b1;
         end
         OP_INC: begin
            add_x  = opd_i;
            add_y  = '0;
            add_ci = 1'b1;
         end
         OP_DEC: begin
            add_x = opd_i;
            add_y = '1;
         end
         default: ;
      endcase
   end

   acc_nib_adder #(.DATA_W(DATA_W)) u_add (
      .x_i     (add_x),
      .y_i     (add_y),
      .ci_i    (add_ci),
      .sum_o   (add_sum),
      .nib_c_o (add_nib),
      .co_o    (add_co)
   );

   logic [DATA_W-1:0] lu_res;
   logic              lu_cy, lu_ac;

   acc_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .op_i  (op),
      .a_i   (acc_i),
      .b_i   (opd_i),
      .cy_i  (cy_in),
      .res_o (lu_res),
      .cy_o  (lu_cy),
      .ac_o  (lu_ac)
   );

   logic [DATA_W-1:0] da_res;
   logic              da_ac, da_cy;

   acc_dec_adjust #(.DATA_W(DATA_W)) u_dadj (
      .a_i   (acc_i),
      .ac_i  (ac_in),
      .cy_i  (cy_in),
      .res_o (da_res),
      .ac_o  (da_ac),
      .cy_o  (da_cy)
   );

   // result select and flag assembly
   logic [DATA_W-1:0] res_n, szp_src;
   logic              upd_szp, nx_cy, nx_ac;
   logic [7:0]        flg_n;

   always_comb begin
      res_n   = acc_i;
      szp_src = acc_i;
      upd_szp = 1'b0;
      nx_cy   = cy_in;
      nx_ac   = ac_in;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            res_n   = add_sum;
            szp_src = add_sum;
            upd_szp = 1'b1;
            nx_cy   = add_co ^ sub_mode;
            nx_ac   = add_nib;
         end
         OP_CMP: begin
            szp_src = add_sum;
            upd_szp = 1'b1;
            nx_cy   = ~add_co;
            nx_ac   = add_nib;
         end
         OP_INC, OP_DEC: begin
            res_n   = add_sum;
            szp_src = add_sum;
            upd_szp = 1'b1;
            nx_ac   = add_nib;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_n   = lu_res;
            szp_src = lu_res;
            upd_szp = 1'b1;
            nx_cy   = lu_cy;
            nx_ac   = lu_ac;
         end
         OP_CPL, OP_RL, OP_RR, OP_RLT, OP_RRT: begin
            res_n = lu_res;
            nx_cy = lu_cy;
         end
         OP_SETC: nx_cy = 1'b1;
         OP_CMCY: nx_cy = ~cy_in;
         OP_DADJ: begin
            res_n   = da_res;
            szp_src = da_res;
            upd_szp = 1'b1;
            nx_cy   = da_cy;
            nx_ac   = da_ac;
         end
         default: ;
      endcase

      flg_n        = '0;
      flg_n[FB_S]  = upd_szp ? szp_src[MSB]     : flg_i[FB_S];
      flg_n[FB_Z]  = upd_szp ? (szp_src == '0)  : flg_i[FB_Z];
      flg_n[FB_P]  = upd_szp ? ~(^szp_src)      : flg_i[FB_P];
      flg_n[FB_AC] = nx_ac;
      flg_n[FB_CY] = nx_cy;
   end

   assign res_o = res_n;
   assign flg_o = flg_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         flg_q <= '0;
      end else if (wr_en_i) begin
         res_q <= res_n;
         flg_q <= flg_n;
      end
   end

   // checks beside the logic they guard
   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (res_q == $past(res_o)) && (flg_q == $past(flg_o))); // R11
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(res_q) && $stable(flg_q)); // R11
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_o & ~FLAG_USED) == 8'h00); // R1
   AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd7) |-> (res_o == acc_i)); // R5
   AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd8 || op_i == 5'd9) |-> (flg_o[FB_CY] == flg_i[FB_CY])); // R6
   AST_CPL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd10) |-> (flg_o == (flg_i & FLAG_USED))); // R7
   AST_LOGIC_CY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 5'd4 && op_i <= 5'd6) |-> !flg_o[FB_CY]); // R4
   AST_SETC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd15) |-> flg_o[FB_CY] && (res_o == acc_i)); // R9
   AST_DADJ_CY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 5'd17 && flg_i[FB_CY]) |-> flg_o[FB_CY]); // R10

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_i = '0;
   logic [7:0] acc_i = '0, opd_i = '0, flg_i = '0;
   logic       wr_en_i = 1'b0;
   logic [7:0] res_o, flg_o, res_q, flg_q;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   logic [7:0] exp_rq = '0, exp_fq = '0;

   always #5 clk = ~clk;

   acc_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
      .flg_i(flg_i), .wr_en_i(wr_en_i), .res_o(res_o), .flg_o(flg_o),
      .res_q(res_q), .flg_q(flg_q)
   );

   function automatic string tag_of(int op);
      case (op)
         0, 1:           return "R2";
         2, 3:           return "R3";
         4, 5, 6:        return "R4";
         7:              return "R5";
         8, 9:           return "R6";
         10:             return "R7";
         11, 12, 13, 14: return "R8";
         15, 16:         return "R9";
         17:             return "R10";
         default:        return "R12";
      endcase
   endfunction

   // behavioural model: returns {result, status}
   function automatic logic [15:0] model(int op, int a, int b, int f);
      int cy = f & 1;
      int ac = (f >> 4) & 1;
      int s  = (f >> 7) & 1;
      int z  = (f >> 6) & 1;
      int p  = (f >> 2) & 1;
      int r  = a;
      int q  = 0;
      int upd = 0;
      int v, cin, lo, t;
      logic [7:0] qb;
      int fl;
      case (op)
         0, 1: begin
            cin = (op == 1) ? cy : 0;
            v = a + b + cin;
            ac = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
            cy = (v > 255) ? 1 : 0;
            r = v & 255; q = r; upd = 1;
         end
         2, 3, 7: begin
            cin = (op == 3) ? 1 - cy : 1;
            v = a + (255 - b) + cin;
            ac = (((a & 15) + (15 - (b & 15)) + cin) > 15) ? 1 : 0;
            cy = (v > 255) ? 0 : 1;
            q = v & 255; upd = 1;
            r = (op == 7) ? a : q;
         end
         4: begin r = a & b; cy = 0; ac = 1; q = r; upd = 1; end
         5: begin r = a | b; cy = 0; ac = 0; q = r; upd = 1; end
         6: begin r = a ^ b; cy = 0; ac = 0; q = r; upd = 1; end
         8: begin
            ac = (((b & 15) + 1) > 15) ? 1 : 0;
            r = (b + 1) & 255; q = r; upd = 1;
         end
         9: begin
            ac = ((b & 15) != 0) ? 1 : 0;
            r = (b + 255) & 255; q = r; upd = 1;
         end
         10: r = 255 - a;
         11: begin cy = (a >> 7) & 1; r = ((a << 1) & 255) | cy; end
         12: begin cy = a & 1; r = (a >> 1) | (cy << 7); end
         13: begin r = ((a << 1) & 255) | cy; cy = (a >> 7) & 1; end
         14: begin r = (a >> 1) | (cy << 7); cy = a & 1; end
         15: cy = 1;
         16: cy = 1 - cy;
         17: begin
            lo = a & 15;
            t = a;
            if (lo > 9 || ac == 1) begin
               ac = (lo + 6 > 15) ? 1 : 0;
               t = a + 6;
            end else ac = 0;
            if (((t >> 4) & 15) > 9 || cy == 1 || t > 255) begin
               t = (t & 255) + 96;
               cy = 1;
            end else cy = 0;
            r = t & 255; q = r; upd = 1;
         end
         default: ;
      endcase
      if (upd == 1) begin
         qb = q[7:0];
         s = (q >> 7) & 1;
         z = (q == 0) ? 1 : 0;
         p = ($countones(qb) % 2 == 0) ? 1 : 0;
      end
      fl = (s << 7) | (z << 6) | (ac << 4) | (p << 2) | cy;
      return {r[7:0], fl[7:0]};
   endfunction

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h (op %0d acc %02h opd %02h flg %02h)",
                  req, what, act, exp, op_i, acc_i, opd_i, flg_i);
      end
   endtask

   // drive one cycle, then compare at the next falling edge
   task automatic step(int op, int a, int b, int f, bit we);
      logic [15:0] m;
      op_i = op[4:0]; acc_i = a[7:0]; opd_i = b[7:0]; flg_i = f[7:0]; wr_en_i = we;
      @(negedge clk);
      m = model(op, a, b, f);
      if (we) begin
         exp_rq = m[15:8];
         exp_fq = m[7:0];
      end
      check(tag_of(op), "result", res_o, m[15:8]);
      check(tag_of(op), "status", flg_o, m[7:0]);
      check("R11", "reg result", res_q, exp_rq);
      check("R11", "reg status", flg_q, exp_fq);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11", "reset result", res_q, 8'h00);
      check("R11", "reset status", flg_q, 8'h00);
      rst_n = 1'b1;

      // R2 add example and carry out
      step(0, 8'h93, 8'hB7, 0, 1);
      check("R2", "93+B7 result", res_o, 8'h4A);
      check("R2", "93+B7 carry", {7'd0, flg_o[0]}, 8'h01);
      step(1, 8'hFF, 8'h00, 1, 1);
      // R3 subtract with and without borrow
      step(2, 8'h97, 8'h65, 0, 1);
      check("R3", "97-65", res_o, 8'h32);
      step(2, 8'h65, 8'h97, 0, 1);
      check("R3", "65-97 borrow", {7'd0, flg_o[0]}, 8'h01);
      step(3, 8'h85, 8'h62, 1, 1);
      check("R3", "85-62-1", res_o, 8'h22);
      // R4 logic flags, inputs with unused bits set (R1)
      step(4, 8'hF0, 8'h3C, 8'hFF, 1);
      check("R4", "AND status", flg_o, 8'h14);
      step(5, 8'h00, 8'h00, 8'hFF, 1);
      check("R1", "OR zero status", flg_o, 8'h44);
      step(6, 8'hAA, 8'h55, 8'h11, 0);
      // R5 compare: below, equal, above
      step(7, 8'h10, 8'h20, 0, 1);
      check("R5", "below CY", {7'd0, flg_o[0]}, 8'h01);
      step(7, 8'h42, 8'h42, 0, 1);
      check("R5", "equal Z,CY", {6'd0, flg_o[6], flg_o[0]}, 8'h02);
      step(7, 8'h80, 8'h01, 0, 1);
      // R6 increment and decrement around wrap, carry kept
      step(8, 0, 8'hFF, 1, 1);
      step(8, 0, 8'h0F, 0, 1);
      step(9, 0, 8'h00, 1, 1);
      step(9, 0, 8'h01, 0, 1);
      // R7 complement
      step(10, 8'h5A, 0, 8'hD5, 1);
      // R8 rotates in all four forms, both carry values
      for (int k = 11; k <= 14; k++) begin
         step(k, 8'h81, 0, 0, 1);
         step(k, 8'h42, 0, 1, 1);
      end
      // R9 carry set and flip
      step(15, 8'h33, 0, 8'h44, 1);
      step(16, 8'h33, 0, 8'h01, 1);
      // R10 decimal adjust corner cases
      step(17, 8'hBA, 0, 0, 1);
      check("R10", "BA adjust", res_o, 8'h20);
      check("R10", "BA carry", {7'd0, flg_o[0]}, 8'h01);
      step(17, 8'h9A, 0, 0, 1);
      step(17, 8'hFF, 0, 0, 1);
      step(17, 8'h15, 0, 8'h10, 1);
      step(17, 8'h25, 0, 8'h01, 1);
      // R11 strobe low holds registers
      step(0, 8'h01, 8'h01, 0, 0);
      step(2, 8'h07, 8'h09, 0, 0);
      // R12 reserved codes
      for (int k = 18; k < 32; k++) step(k, 8'hC3, 8'h11, 8'hFF, 1);

      // mixed stimulus over every code
      for (int i = 0; i < 4000; i++) begin
         step(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
              1'($urandom_range(0, 1)));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule